// File: doc/BRIEF.md
# Row Scan Shift Register

This block is the row-side scan register of an 80-output display driver. A scan bit is loaded at one end of the register on each falling edge of the line clock. It then moves one position per line clock. The bit that falls off the far end is presented on an edge pin, so that several drivers can be chained.

A mode input selects one of two arrangements. In single mode all stages form one chain. In dual mode the register splits into two independent half chains, and the second half takes its own input from a middle pin. This lets two halves of a panel be scanned at the same time. A direction input reverses the chain. It also swaps the edge pins, so that one acts as the input and the other as the output.

Each stage is turned into a 2-bit drive-level code for the analog output stage. The code depends on the stage bit and the frame-inversion input. An active-low blanking input overrides every output.

Top module: `row_scan_shifter`

## Requirements
- R1: After reset every stage holds 0 and the edge output holds 0.
- R2: The register and the edge output change only at the first rising `clk` edge at which `line_clk` is sampled low after having been sampled high at the previous edge. At every other edge they keep their value.
- R3: Single mode, `dir_rev`=0. Stage 1 loads `left_in` and each stage k>1 takes the old stage k-1. The edge output takes the old stage STAGES.
- R4: Single mode, `dir_rev`=1. Stage STAGES loads `right_in` and each stage k<STAGES takes the old stage k+1. The edge output takes the old stage 1.
- R5: Dual mode, `dir_rev`=0. Stage 1 loads `left_in` and stage STAGES/2+1 loads `mid_in`. The other stages shift upward. The old stage STAGES/2 is discarded, and the old stage STAGES goes to the edge output.
- R6: Dual mode, `dir_rev`=1. Stage STAGES loads `right_in` and stage STAGES/2 loads `mid_in`. The other stages shift downward. The old stage STAGES/2+1 is discarded, and the old stage 1 goes to the edge output.
- R7: `right_oe` = NOT `dir_rev` and `left_oe` = `dir_rev`. Both `left_out` and `right_out` carry the edge output.
- R8: With `blank_n`=1, the code for stage k sits at `drive_lvl[2k-1:2k-2]`. The codes are: frame 0 with bit 0 gives 1 (upper non-select); frame 0 with bit 1 gives 3 (bottom select); frame 1 with bit 0 gives 2 (lower non-select); frame 1 with bit 1 gives 0 (top select).
- R9: With `blank_n`=0, every code is 0 (top level), whatever the stage bits and the frame input. The stage contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_clk | input | 1 | Line clock; the register shifts on its falling edge |
| dual_mode | input | 1 | 0: one chain; 1: two half chains |
| dir_rev | input | 1 | 0: shift toward stage STAGES; 1: toward stage 1 |
| frame_inv | input | 1 | Frame inversion signal |
| blank_n | input | 1 | Active-low display blanking |
| left_in | input | 1 | Left edge scan input (used when dir_rev=0) |
| mid_in | input | 1 | Second scan input in dual mode |
| right_in | input | 1 | Right edge scan input (used when dir_rev=1) |
| left_out | output | 1 | Edge output value on the left pin |
| left_oe | output | 1 | Left pin output enable |
| right_out | output | 1 | Edge output value on the right pin |
| right_oe | output | 1 | Right pin output enable |
| drive_lvl | output | 2*STAGES | Per-stage 2-bit drive-level codes |

## Verification
The bench keeps its own model of the register. It checks the whole code vector after each line-clock step, cycling through all four combinations of mode and direction.

The middle boundary gets the most attention. A design that let the half chains leak into each other in dual mode would carry left-half bits into stage STAGES/2+1, and the vector compare would catch it. A design that loaded `mid_in` into the wrong stage for the reversed direction would be caught the same way.

Some steps hold the line clock high with no falling edge. If the design shifted on the wrong edge, or on every clock, these steps would show it. Random frame and blanking values check that the code mapping and the forced top level leave the stored bits untouched.

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
  parameter int STAGES = 80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_clk,
  input  logic                  dual_mode,
  input  logic                  dir_rev,
  input  logic                  frame_inv,
  input  logic                  blank_n,
  input  logic                  left_in,
  input  logic                  mid_in,
  input  logic                  right_in,
  output logic                  left_out,
  output logic                  left_oe,
  output logic                  right_out,
  output logic                  right_oe,
  output logic [2*STAGES-1:0]   drive_lvl
);
  localparam int HALF = STAGES / 2;

  logic              line_q;
  logic              edge_q;
  logic [STAGES-1:0] sh;
  logic [STAGES-1:0] nxt;

  wire shift = line_q & ~line_clk;

  always_comb begin
    if (!dir_rev) begin
      nxt = {sh[STAGES-2:0], left_in};
      if (dual_mode) nxt[HALF] = mid_in;
    end else begin
      nxt = {right_in, sh[STAGES-1:1]};
      if (dual_mode) nxt[HALF-1] = mid_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      sh     <= '0;
      edge_q <= 1'b0;
    end else begin
      line_q <= line_clk;
      if (shift) begin
        sh     <= nxt;
        edge_q <= dir_rev ? sh[0] : sh[STAGES-1];
      end
    end
  end

  assign left_out  = edge_q;
  assign right_out = edge_q;
  assign left_oe   = dir_rev;
  assign right_oe  = ~dir_rev;

  for (genvar g = 0; g < STAGES; g++) begin : g_lvl
    assign drive_lvl[2*g +: 2] = blank_n ? {frame_inv ^ sh[g], ~frame_inv} : 2'd0;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> ($stable(sh) && $stable(edge_q)));

  // R3
  single_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !dual_mode && !dir_rev) |=>
      (sh[0] == $past(left_in) && edge_q == $past(sh[STAGES-1])));

  // R4
  single_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !dual_mode && dir_rev) |=>
      (sh[STAGES-1] == $past(right_in) && edge_q == $past(sh[0])));

  // R5
  dual_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && dual_mode && !dir_rev) |=>
      (sh[0] == $past(left_in) && sh[HALF] == $past(mid_in)));

  // R6
  dual_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && dual_mode && dir_rev) |=>
      (sh[STAGES-1] == $past(right_in) && sh[HALF-1] == $past(mid_in)));
endmodule

// File: tb/sim_row_scan_shifter.sv
module sim_row_scan_shifter;
  localparam int PERIOD = 10;
  localparam int N = 80;
  localparam int H = N / 2;

  logic clk = 0, rst_n = 0, line_clk = 0, dual_mode = 0, dir_rev = 0;
  logic frame_inv = 0, blank_n = 1, left_in = 0, mid_in = 0, right_in = 0;
  logic left_out, left_oe, right_out, right_oe;
  logic [2*N-1:0] drive_lvl;

  int checks = 0, fails = 0;
  bit model [N];
  bit model_out;

  always #(PERIOD/2) clk = ~clk;

  row_scan_shifter #(.STAGES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .dual_mode(dual_mode),
    .dir_rev(dir_rev), .frame_inv(frame_inv), .blank_n(blank_n),
    .left_in(left_in), .mid_in(mid_in), .right_in(right_in),
    .left_out(left_out), .left_oe(left_oe), .right_out(right_out),
    .right_oe(right_oe), .drive_lvl(drive_lvl));

  function automatic logic [1:0] code(bit f, bit b, bit bl_n);
    if (!bl_n) return 2'd0;
    case ({f, b})
      2'b00: return 2'd1;
      2'b01: return 2'd3;
      2'b10: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [2*N-1:0] exp_vec();
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = code(frame_inv, model[i], blank_n);
    return v;
  endfunction

  task automatic check(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_shift();
    if (!dir_rev) begin
      model_out = model[N-1];
      for (int i = N-1; i > 0; i--) model[i] = model[i-1];
      model[0] = left_in;
      if (dual_mode) model[H] = mid_in;
    end else begin
      model_out = model[0];
      for (int i = 0; i < N-1; i++) model[i] = model[i+1];
      model[N-1] = right_in;
      if (dual_mode) model[H-1] = mid_in;
    end
  endtask

  task automatic step(bit do_fall, bit l, bit m, bit r, bit f, bit bl);
    string tag;
    @(negedge clk);
    line_clk = 1; left_in = l; mid_in = m; right_in = r; frame_inv = f; blank_n = bl;
    @(negedge clk);
    if (do_fall) line_clk = 0;
    @(negedge clk);
    if (do_fall) model_shift();
    if (!bl) tag = "R9";
    else if (!do_fall) tag = "R2";
    else if (f) tag = "R8";
    else case ({dual_mode, dir_rev})
      2'b00: tag = "R3";
      2'b01: tag = "R4";
      2'b10: tag = "R5";
      default: tag = "R6";
    endcase
    check(tag, drive_lvl, exp_vec());
    check("R7 edge", {left_out, right_out}, {model_out, model_out});
    check("R7 oe", {left_oe, right_oe}, {dir_rev, ~dir_rev});
  endtask

  initial begin
    #(PERIOD*150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) model[i] = 0;
    model_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: cleared stages, frame 0 -> code 1 everywhere
    check("R1", drive_lvl, exp_vec());
    check("R1 edge", {left_out, right_out}, 2'b00);

    // Directed: dual forward, token walks to end of first half and must not cross (R5)
    dual_mode = 1; dir_rev = 0;
    step(1, 1, 0, 0, 0, 1);
    for (int k = 0; k < H + 2; k++) step(1, 0, 0, 0, 0, 1);
    check("R5 boundary", drive_lvl, {(2*N/2){2'b01}});

    // Directed: dual reverse, token from right half must not cross (R6)
    dir_rev = 1;
    step(1, 0, 0, 1, 0, 1);
    for (int k = 0; k < H + 2; k++) step(1, 0, 0, 0, 0, 1);
    check("R6 boundary", drive_lvl, {(2*N/2){2'b01}});

    // Directed: single forward, token passes through all stages to the edge (R3)
    dual_mode = 0; dir_rev = 0;
    step(1, 1, 0, 0, 0, 1);
    for (int k = 0; k < N - 1; k++) step(1, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 1);
    check("R3 edge token", {right_out, right_oe}, 2'b11);

    // Random blocks over all mode/direction pairs
    for (int blk = 0; blk < 16; blk++) begin
      @(negedge clk);
      dual_mode = blk[0]; dir_rev = blk[1];
      for (int k = 0; k < 70; k++)
        step(($urandom % 5) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), ($urandom % 8) != 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule